// File: doc/BRIEF.md
# Injected Event Frame Decision Unit

This unit makes the frame decisions for an event that is injected into a guest during virtual-machine entry. A start strobe captures the interruption-information word, the error-code word, the instruction length and the current guest instruction pointer. From these it works out the instruction pointer to push, whether an error code is pushed, and which error word is pushed.

The unit then follows the delivery as it happens. Each exception raised while the event, or a later exception, is being delivered is reported on a nested-exception strobe together with its vector. For each one the unit decides two things. First, whether the exception forces an exit or is delivered, using the exception bitmap. Second, the EXT bit of that exception's error code. It also promotes an over-deep nesting to a double fault.

When the first nested exception forces an exit, the unit copies the injected event's information word to a vectoring-information output. Walking the descriptor table, writing the stack and switching tasks belong to other blocks.

Top module: `inj_frame_top`

## Requirements
- R1: Injection is active only when bit 31 of the captured information word is 1. With that bit at 0, injActive, pushErr, vecValid, nestExit and nestDeliver stay 0, and later nested strobes are ignored: done stays 0 and the outputs do not change.
- R2: For type field bits 10:8 equal to 0 (external interrupt), 2 (NMI), 3 (hardware exception), or the unused codes 1 and 7, pushIp equals the captured instruction pointer.
- R3: For type 4 (software interrupt), 5 (privileged software exception) or 6 (software exception), pushIp equals the captured pointer plus instLen, modulo 2^IP_W.
- R4: The first accepted nested exception returns pushIp to the captured pointer, whatever the type and length, and whether or not that exception forces an exit.
- R5: A nested exception forces an exit (nestExit) when bit v of excBitmap is 1, where v is its vector. Otherwise it is delivered (nestDeliver). Vectors of 32 or more are always delivered. A double fault looks up bit 8.
- R6: pushErr equals bit 31 AND bit 11 of the information word. pushErrCode carries the captured error-code word.
- R7: The first nested exception has nestExt set for every type except 4 and 6, which clear it.
- R8: Each nested exception after the first, up to MAX_NEST in total, sets nestExt. The next one becomes a double fault: nestDf is 1, nestVecOut is 8, and nestExt is 0 (an all-zero error code).
- R9: After an exit, or after a double fault, nested strobes are ignored until the next start: done stays 0 and the outputs hold.
- R10: vecValid rises, and vecInfo takes the full captured information word, only when the first nested exception forces an exit. A start clears both.
- R11: done pulses for one cycle after each accepted strobe, and the decision outputs are valid in that same cycle. A start and a nested strobe in the same cycle count as a start only.
- R12: The injected event itself never forces an exit. Right after a start, nestExit and nestDeliver are both 0, whatever excBitmap holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Capture a new event to inject |
| intInfo | input | 32 | Interruption-information word (valid 31, deliver-code 11, type 10:8, vector 7:0) |
| errCode | input | 32 | Error-code word for the injected event |
| instLen | input | LEN_W | Instruction length |
| curIp | input | IP_W | Current guest instruction pointer |
| excBitmap | input | 32 | Exception bitmap, one bit per vector 0..31 |
| nestStb | input | 1 | A nested exception was raised during delivery |
| nestVec | input | 8 | Vector of that nested exception |
| done | output | 1 | One-cycle pulse: decisions updated |
| injActive | output | 1 | Captured event is valid |
| pushIp | output | IP_W | Instruction pointer to push |
| pushErr | output | 1 | An error code is pushed for the injected event |
| pushErrCode | output | 32 | Error code to push |
| nestVecOut | output | 8 | Vector of the latest nested exception (8 for double fault) |
| nestDeliver | output | 1 | Latest nested exception is delivered |
| nestExit | output | 1 | Latest nested exception forces an exit |
| nestExt | output | 1 | EXT bit of the latest nested error code |
| nestDf | output | 1 | Latest nested exception became a double fault |
| vecValid | output | 1 | Vectoring information is valid |
| vecInfo | output | 32 | Saved information word of the injected event |

## Verification
A wrong nesting depth shows up at the ports within one nested strobe. Either nestExt reads 1 where a first-level 0 was due, or the double fault appears one exception early or late, and that shows in nestDf and nestVecOut on the done pulse. A state that fails to terminate shows on the first strobe after an exit, as an unexpected done pulse. A stale pointer base shows in pushIp in the cycle right after the first nested strobe. Random sessions mix all eight type codes, vectors above and below 32, and random bitmaps. Directed cases cover pointer wrap, a double fault that exits, and a start and a nested strobe in the same cycle.

// File: rtl/inj_frame_pkg.sv
package inj_frame_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LIVE, ST_END} ctrlState_t;
  typedef enum logic [1:0] {NL_FIRST, NL_DEEP, NL_DF} nestLevel_t;

  typedef struct packed {
    logic       capture;
    logic       takeNest;
    nestLevel_t level;
  } dpCmd_t;

  localparam int VALID_BIT = 31;
  localparam int ERRV_BIT  = 11;
  localparam int TYPE_LO   = 8;
  localparam logic [7:0] DF_VECTOR = 8'd8;

  function automatic logic advancesIp(input logic [2:0] kind);
    return (kind == 3'd4) || (kind == 3'd5) || (kind == 3'd6);
  endfunction

  function automatic logic softKind(input logic [2:0] kind);
    return (kind == 3'd4) || (kind == 3'd6);
  endfunction

endpackage

// File: rtl/inj_frame_ctrl.sv
module inj_frame_ctrl
  import inj_frame_pkg::*;
#(
  parameter int MAX_NEST = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startStb,
  input  logic   startValid,
  input  logic   nestStb,
  input  logic   nestHitExit,
  output dpCmd_t cmd,
  output logic   doneOut
);
  localparam int DEPTH_W = $clog2(MAX_NEST + 1);

  ctrlState_t state;
  logic [DEPTH_W-1:0] depth;

  always_comb begin
    cmd = '{capture: 1'b0, takeNest: 1'b0, level: NL_FIRST};
    if (startStb) begin
      cmd.capture = 1'b1;
    end else if (nestStb && state == ST_LIVE) begin
      cmd.takeNest = 1'b1;
      if (depth == '0)                          cmd.level = NL_FIRST;
      else if (depth >= DEPTH_W'(MAX_NEST))     cmd.level = NL_DF;
      else                                      cmd.level = NL_DEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      depth   <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= cmd.capture | cmd.takeNest;
      if (cmd.capture) begin
        state <= startValid ? ST_LIVE : ST_IDLE;
        depth <= '0;
      end else if (cmd.takeNest) begin
        if (cmd.level == NL_DF || nestHitExit) state <= ST_END;
        else                                   depth <= depth + 1'b1;
      end
    end
  end

endmodule

// File: rtl/inj_frame_dp.sv
module inj_frame_dp
  import inj_frame_pkg::*;
#(
  parameter int IP_W  = 64,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [31:0]      intInfo,
  input  logic [31:0]      errCode,
  input  logic [LEN_W-1:0] instLen,
  input  logic [IP_W-1:0]  curIp,
  input  logic [31:0]      excBitmap,
  input  logic [7:0]       nestVec,
  output logic             hitExit,
  output logic             injActive,
  output logic [IP_W-1:0]  pushIp,
  output logic             pushErr,
  output logic [31:0]      pushErrCode,
  output logic [7:0]       nestVecOut,
  output logic             nestDeliver,
  output logic             nestExit,
  output logic             nestExt,
  output logic             nestDf,
  output logic             vecValid,
  output logic [31:0]      vecInfo
);
  logic [31:0]     infoQ;
  logic [IP_W-1:0] ipBase;
  logic [7:0]      selVec;
  logic [2:0]      curKind;
  logic            extNext;

  assign curKind = infoQ[TYPE_LO +: 3];
  assign selVec  = (cmd.level == NL_DF) ? DF_VECTOR : nestVec;
  assign hitExit = (selVec[7:5] == 3'd0) && excBitmap[selVec[4:0]];

  always_comb begin
    case (cmd.level)
      NL_FIRST: extNext = !softKind(curKind);
      NL_DEEP:  extNext = 1'b1;
      default:  extNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      infoQ <= '0; ipBase <= '0; pushIp <= '0;
      injActive <= 1'b0; pushErr <= 1'b0; pushErrCode <= '0;
      nestVecOut <= '0; nestDeliver <= 1'b0; nestExit <= 1'b0;
      nestExt <= 1'b0; nestDf <= 1'b0; vecValid <= 1'b0; vecInfo <= '0;
    end else if (cmd.capture) begin
      infoQ       <= intInfo;
      ipBase      <= curIp;
      pushIp      <= advancesIp(intInfo[TYPE_LO +: 3])
                     ? curIp + {{(IP_W-LEN_W){1'b0}}, instLen} : curIp;
      injActive   <= intInfo[VALID_BIT];
      pushErr     <= intInfo[VALID_BIT] & intInfo[ERRV_BIT];
      pushErrCode <= errCode;
      nestVecOut  <= '0;
      nestDeliver <= 1'b0;
      nestExit    <= 1'b0;
      nestExt     <= 1'b0;
      nestDf      <= 1'b0;
      vecValid    <= 1'b0;
      vecInfo     <= '0;
    end else if (cmd.takeNest) begin
      nestVecOut  <= selVec;
      nestExit    <= hitExit;
      nestDeliver <= !hitExit;
      nestExt     <= extNext;
      nestDf      <= (cmd.level == NL_DF);
      if (cmd.level == NL_FIRST) begin
        pushIp <= ipBase;
        if (hitExit) begin
          vecValid <= 1'b1;
          vecInfo  <= infoQ;
        end
      end
    end
  end

endmodule

// File: rtl/inj_frame_top.sv
module inj_frame_top
  import inj_frame_pkg::*;
#(
  parameter int IP_W     = 64,
  parameter int LEN_W    = 4,
  parameter int MAX_NEST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [31:0]      intInfo,
  input  logic [31:0]      errCode,
  input  logic [LEN_W-1:0] instLen,
  input  logic [IP_W-1:0]  curIp,
  input  logic [31:0]      excBitmap,
  input  logic             nestStb,
  input  logic [7:0]       nestVec,
  output logic             done,
  output logic             injActive,
  output logic [IP_W-1:0]  pushIp,
  output logic             pushErr,
  output logic [31:0]      pushErrCode,
  output logic [7:0]       nestVecOut,
  output logic             nestDeliver,
  output logic             nestExit,
  output logic             nestExt,
  output logic             nestDf,
  output logic             vecValid,
  output logic [31:0]      vecInfo
);
  dpCmd_t cmd;
  logic   hitExit;

  inj_frame_ctrl #(.MAX_NEST(MAX_NEST)) uCtrl (
    .clk(clk), .rstN(rstN), .startStb(startStb),
    .startValid(intInfo[VALID_BIT]), .nestStb(nestStb),
    .nestHitExit(hitExit), .cmd(cmd), .doneOut(done)
  );

  inj_frame_dp #(.IP_W(IP_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .intInfo(intInfo),
    .errCode(errCode), .instLen(instLen), .curIp(curIp),
    .excBitmap(excBitmap), .nestVec(nestVec), .hitExit(hitExit),
    .injActive(injActive), .pushIp(pushIp), .pushErr(pushErr),
    .pushErrCode(pushErrCode), .nestVecOut(nestVecOut),
    .nestDeliver(nestDeliver), .nestExit(nestExit), .nestExt(nestExt),
    .nestDf(nestDf), .vecValid(vecValid), .vecInfo(vecInfo)
  );

endmodule

// File: rtl/inj_frame_chk.sv
module inj_frame_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startStb,
  input logic        nestStb,
  input logic        done,
  input logic        injActive,
  input logic        pushErr,
  input logic        nestExit,
  input logic        nestDeliver,
  input logic        nestExt,
  input logic        nestDf,
  input logic        vecValid
);
  // R11
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(startStb || nestStb));

  // R12
  start_no_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(startStb) |-> (!nestExit && !nestDeliver));

  // R5
  exit_or_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nestExit, nestDeliver}));

  // R8
  df_ext_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    nestDf |-> (!nestExt && (nestExit || nestDeliver)));

  // R10
  vec_on_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecValid) |-> (nestExit && $past(nestStb)));

  // R1
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !injActive |-> (!vecValid && !nestExit && !nestDeliver));

  // R6
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushErr |-> injActive);

endmodule

bind inj_frame_top inj_frame_chk uChk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .nestStb(nestStb),
  .done(done), .injActive(injActive), .pushErr(pushErr),
  .nestExit(nestExit), .nestDeliver(nestDeliver), .nestExt(nestExt),
  .nestDf(nestDf), .vecValid(vecValid)
);

// File: tb/tb_inj_frame_top.sv
module tb_inj_frame_top;
  localparam int IP_W = 64, LEN_W = 4, MAX_NEST = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, startStb, nestStb;
  logic [31:0] intInfo, errCode, excBitmap;
  logic [LEN_W-1:0] instLen;
  logic [IP_W-1:0] curIp;
  logic [7:0] nestVec;
  logic done, injActive, pushErr, nestDeliver, nestExit, nestExt, nestDf, vecValid;
  logic [IP_W-1:0] pushIp;
  logic [31:0] pushErrCode, vecInfo;
  logic [7:0] nestVecOut;

  inj_frame_top #(.IP_W(IP_W), .LEN_W(LEN_W), .MAX_NEST(MAX_NEST)) dut (.*);

  int nTests = 0, nFail = 0;
  bit finished = 0;

  bit mActive, mLive, mTerm, mPushErr, mExit, mDeliver, mExt, mDf, mVecValid, mDone;
  int mDepth;
  logic [31:0] mInfo, mErr, mVecInfo;
  logic [IP_W-1:0] mBase, mIp;
  logic [7:0] mNestVec;

  function automatic bit advKind(input logic [2:0] k);
    return k == 3'd4 || k == 3'd5 || k == 3'd6;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "done", 64'(done), 64'(mDone));
    chk(tag, "injActive", 64'(injActive), 64'(mActive));
    if (mActive) chk(tag, "pushIp", pushIp, mIp);
    chk(tag, "pushErr", 64'(pushErr), 64'(mPushErr));
    if (mPushErr) chk(tag, "pushErrCode", 64'(pushErrCode), 64'(mErr));
    chk(tag, "nestExit", 64'(nestExit), 64'(mExit));
    chk(tag, "nestDeliver", 64'(nestDeliver), 64'(mDeliver));
    chk(tag, "nestExt", 64'(nestExt), 64'(mExt));
    chk(tag, "nestDf", 64'(nestDf), 64'(mDf));
    if (mExit || mDeliver) chk(tag, "nestVecOut", 64'(nestVecOut), 64'(mNestVec));
    chk(tag, "vecValid", 64'(vecValid), 64'(mVecValid));
    if (mVecValid) chk(tag, "vecInfo", 64'(vecInfo), 64'(mVecInfo));
  endtask

  task automatic modelStart(input logic [31:0] info, input logic [31:0] err,
                            input logic [LEN_W-1:0] len, input logic [IP_W-1:0] ip);
    mActive = info[31]; mLive = info[31]; mTerm = 0; mDepth = 0;
    mInfo = info; mBase = ip; mErr = err;
    mIp = advKind(info[10:8]) ? ip + IP_W'(len) : ip;
    mPushErr = info[31] & info[11];
    mExit = 0; mDeliver = 0; mExt = 0; mDf = 0; mVecValid = 0; mDone = 1;
  endtask

  task automatic doStart(input logic [31:0] info, input logic [31:0] err,
                         input logic [LEN_W-1:0] len, input logic [IP_W-1:0] ip, input string tag);
    @(negedge clk);
    intInfo = info; errCode = err; instLen = len; curIp = ip; startStb = 1;
    @(posedge clk); #1; startStb = 0;
    modelStart(info, err, len, ip);
    checkAll(tag);
  endtask

  task automatic doNest(input logic [7:0] vec, input string tag);
    bit df, hit, first;
    logic [7:0] sel;
    @(negedge clk);
    nestVec = vec; nestStb = 1;
    @(posedge clk); #1; nestStb = 0;
    if (mLive && !mTerm) begin
      first = (mDepth == 0);
      df = !first && (mDepth >= MAX_NEST);
      sel = df ? 8'd8 : vec;
      hit = (sel < 8'd32) && excBitmap[sel[4:0]];
      mExit = hit; mDeliver = !hit; mDf = df; mNestVec = sel;
      mExt = first ? !(mInfo[10:8] == 3'd4 || mInfo[10:8] == 3'd6) : !df;
      if (first) begin
        mIp = mBase;
        if (hit) begin mVecValid = 1; mVecInfo = mInfo; end
      end
      if (df || hit) mTerm = 1; else mDepth++;
      mDone = 1;
    end else begin
      mDone = 0;
    end
    checkAll(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    rstN = 0; startStb = 0; nestStb = 0; intInfo = 0; errCode = 0;
    instLen = 0; curIp = 0; excBitmap = 0; nestVec = 0;
    mActive = 0; mLive = 0; mTerm = 0; mPushErr = 0; mExit = 0; mDeliver = 0;
    mExt = 0; mDf = 0; mVecValid = 0; mDone = 0; mDepth = 0;
    mInfo = 0; mErr = 0; mVecInfo = 0; mBase = 0; mIp = 0; mNestVec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    checkAll("R1");

    // R1: invalid event, then a nested strobe that must be ignored
    doStart(32'h0000_0B03, 32'h55, 4'd2, 64'h2000, "R1");
    doNest(8'd13, "R1");

    // R2 R6 R12: hardware exception with error code, bitmap all ones
    excBitmap = 32'hFFFF_FFFF;
    doStart(32'h8000_0B0E, 32'h0000_1234, 4'd3, 64'h1000, "R12");
    checkAll("R2"); checkAll("R6");
    excBitmap = 32'h0;
    doNest(8'd14, "R7");
    doNest(8'd13, "R8");
    doNest(8'd6, "R8");
    doNest(8'd6, "R9");

    // R3 R4 R10: software interrupt with pointer wrap, first nested exits
    excBitmap = 32'h0000_2000;
    doStart(32'h8000_0421, 32'h0, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    doNest(8'd13, "R4");
    checkAll("R10");
    doNest(8'd13, "R9");

    // R3 R5 R7: software exception, vector above 31 is delivered
    excBitmap = 32'hFFFF_FFFF;
    doStart(32'h8000_0603, 32'h0, 4'd1, 64'h3000, "R3");
    doNest(8'd40, "R5");

    // R3 R7 R10: privileged software exception, exiting nested
    excBitmap = 32'h0000_0008;
    doStart(32'h8000_0501, 32'h0, 4'd5, 64'h4000, "R3");
    doNest(8'd3, "R7");

    // R10: a deeper exit does not set vectoring information
    excBitmap = 32'h0;
    doStart(32'h8000_0202, 32'h0, 4'd4, 64'h5000, "R2");
    doNest(8'd13, "R7");
    excBitmap = 32'h0000_2000;
    doNest(8'd13, "R10");

    // R5 R8: double fault looks up bit 8 and exits
    excBitmap = 32'h0000_0100;
    doStart(32'h8000_0020, 32'h0, 4'd0, 64'h6000, "R2");
    doNest(8'd11, "R8");
    doNest(8'd12, "R8");
    doNest(8'd13, "R5");
    doNest(8'd13, "R9");

    // R11: start and nested strobe in the same cycle, then a quiet cycle
    doStart(32'h8000_0302, 32'h0, 4'd0, 64'h7000, "R11");
    @(negedge clk);
    intInfo = 32'h8000_0402; instLen = 4'd3; curIp = 64'h7100; errCode = 32'h9;
    startStb = 1; nestStb = 1; nestVec = 8'd2;
    @(posedge clk); #1; startStb = 0; nestStb = 0;
    modelStart(32'h8000_0402, 32'h9, 4'd3, 64'h7100);
    checkAll("R11");
    @(posedge clk); #1;
    mDone = 0;
    chk("R11", "done idle", 64'(done), 64'(mDone));

    // random sessions
    seed = $urandom(32'd2024);
    for (int s = 0; s < 400; s++) begin
      logic [31:0] info;
      int nNest;
      info = $urandom;
      info[31] = ($urandom % 5) != 0;
      excBitmap = $urandom;
      doStart(info, $urandom, LEN_W'($urandom), {$urandom, $urandom},
              advKind(info[10:8]) ? "R3" : "R2");
      nNest = $urandom % 5;
      for (int k = 0; k < nNest; k++) begin
        logic [7:0] v;
        v = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 32);
        if (($urandom % 3) == 0) excBitmap = $urandom;
        doNest(v, (k == 0) ? "R7" : "R8");
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule